// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 512K bytes. The host presents a single-word request together with a 19-bit address, a direction flag and, for writes, one byte of data. The sequencer then drives the memory's three active-low strobes, the address bus and the bidirectional data bus through a sequence of phases that meet the memory's nanosecond timing rules. Each phase lasts a parameterised number of system clock cycles.

A read holds chip select and output enable low for a fixed access count. The returned byte is captured on the clock edge that ends that count, and a one-cycle valid pulse follows. The strobes are then released, and the data bus stays undriven for a turn-around count so that the memory can finish releasing the bus. A write holds output enable high throughout and pulses write enable low with chip select low for a set count, driving the byte for the whole pulse. The data stays driven for one extra cycle after both strobes rise, which gives hold time.

The host handshake has a ready flag. A request is taken only when ready is high, and ready stays low until the whole sequence has finished. The address on the memory bus is held steady for the whole of each access.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, ready is 1 and rd_valid is 0.
- R2: After a read is accepted (req=1, req_wr=0 with ready=1 at a clock edge), the next RD_CYC cycles have mem_ce_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0, with mem_addr equal to the accepted address.
- R3: The byte on mem_dq_in is captured at the edge that ends the read access. For the following single cycle rd_valid=1 and rd_data holds that byte. rd_data keeps the byte after rd_valid falls.
- R4: After a read access, mem_ce_n and mem_oe_n are 1 and mem_dq_oe is 0 for TURN_CYC cycles before the block returns to idle.
- R5: After a write is accepted (req_wr=1), the next WE_CYC cycles have mem_we_n=0, mem_ce_n=0, mem_oe_n=1 and mem_dq_oe=1, with mem_dq_out equal to the accepted byte and mem_addr equal to the accepted address.
- R6: After the write pulse there is one cycle with mem_we_n=1, mem_ce_n=1, mem_dq_oe=1 and the same byte on mem_dq_out. mem_dq_oe is 0 from the next cycle on.
- R7: ready is 0 from the cycle after acceptance until the sequence ends. A req raised while ready is 0 starts no access and changes no memory content.
- R8: mem_dq_oe is never 1 while mem_oe_n is 0, and mem_we_n is never 0 while mem_ce_n is 1.
- R9: mem_addr does not change while ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Controller can accept a request |
| rd_valid | output | 1 | One-cycle pulse: rd_data is fresh |
| rd_data | output | 8 | Captured read byte |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_out | output | 8 | Data to the memory bus |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 8 | Data read from the memory bus |

## Verification
Assertions check the bus-safety rules on every cycle. The controller never drives the data bus while the memory's outputs are enabled. Write enable never falls without chip select. The address stays frozen while busy. The read-valid flag never lasts two cycles. Only the bench's scenarios can show that each phase has the exact length and order, that the captured byte matches what an earlier write stored at that address, and that a request raised while busy leaves memory contents alone. The scenarios include back-to-back write/read and read/write at the ends of the address range, and random mixes of reads and writes.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_REL  = 3'd2,
    ST_WR   = 3'd3,
    ST_HOLD = 3'd4
  } sram_st_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_accept,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              drive_d,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [DATA_W-1:0] wbuf_d, rbuf_d;

  always_comb begin
    wbuf_d = dq_out;
    if (wr_accept) wbuf_d = wdata_in;
    rbuf_d = rd_data;
    if (capture)   rbuf_d = dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      dq_out   <= wbuf_d;
      dq_oe    <= drive_d;
      rd_data  <= rbuf_d;
      rd_valid <= capture;
    end
  end

  // R3: read-valid is a single-cycle pulse
  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R6: driven data does not change while the drivers are on
  a_r6_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe && $past(dq_oe) |-> $stable(dq_out));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RD_CYC   = 3,
  parameter int unsigned WE_CYC   = 2,
  parameter int unsigned TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned LONGEST = max3(RD_CYC, WE_CYC, TURN_CYC);
  localparam int unsigned CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;
  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LD   = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  sram_st_e         st_q, st_d;
  logic             accept, phase_done, load, capture, drive_d;
  logic [CNT_W-1:0] load_val;
  logic             ce_n_d, oe_n_d, we_n_d, ready_d;
  logic [ADDR_W-1:0] addr_d;

  assign accept = req && ready;

  // next-state and phase-timer control
  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    load_val = '0;
    capture  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        load = 1'b1;
        if (req_wr) begin st_d = ST_WR; load_val = WE_LD; end
        else        begin st_d = ST_RD; load_val = RD_LD; end
      end
      ST_RD: if (phase_done) begin
        st_d     = ST_REL;
        load     = 1'b1;
        load_val = TURN_LD;
        capture  = 1'b1;
      end
      ST_REL:  if (phase_done) st_d = ST_IDLE;
      ST_WR:   if (phase_done) st_d = ST_HOLD;
      ST_HOLD: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // strobe values for the coming cycle, registered below
  always_comb begin
    ce_n_d  = !((st_d == ST_RD) || (st_d == ST_WR));
    oe_n_d  = (st_d != ST_RD);
    we_n_d  = (st_d != ST_WR);
    ready_d = (st_d == ST_IDLE);
    drive_d = (st_d == ST_WR) || (st_d == ST_HOLD);
    addr_d  = accept ? req_addr : mem_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      mem_ce_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_we_n <= 1'b1;
      ready    <= 1'b1;
      mem_addr <= '0;
    end else begin
      st_q     <= st_d;
      mem_ce_n <= ce_n_d;
      mem_oe_n <= oe_n_d;
      mem_we_n <= we_n_d;
      ready    <= ready_d;
      mem_addr <= addr_d;
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .done     (phase_done)
  );

  sram_dq_path #(.DATA_W(DATA_W)) dq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_accept (accept && req_wr),
    .wdata_in  (req_wdata),
    .drive_d   (drive_d),
    .capture   (capture),
    .dq_in     (mem_dq_in),
    .dq_out    (mem_dq_out),
    .dq_oe     (mem_dq_oe),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  // R8: no bus fight with the memory's output drivers
  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  // R8: write enable only inside chip select
  a_r8_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  // R9: address frozen while busy
  a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ready && $past(!ready) |-> $stable(mem_addr));

  // R2: read strobes never overlap a write pulse
  a_r2_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n && mem_we_n);

  // R5: drivers on during the whole write pulse
  a_r5_pulse_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe && mem_oe_n);

  // R7: when ready the memory is deselected
  a_r7_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> mem_ce_n && mem_we_n && mem_oe_n);

  // R4: after a read access the drivers stay off for at least one cycle
  a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !mem_dq_oe);

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

  localparam int AW = 19;
  localparam int DW = 8;
  localparam int RD = 3;
  localparam int WE = 2;
  localparam int TA = 1;

  logic          clk, rst_n, req, req_wr;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          ready, rd_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  int nchk = 0;
  int nfail = 0;

  logic [DW-1:0] model_mem [logic [AW-1:0]];
  logic [DW-1:0] exp_mem   [logic [AW-1:0]];

  sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WE_CYC(WE), .TURN_CYC(TA)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : init_val(a);
  endfunction

  // memory model: stores during the write pulse, drives when read-enabled
  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) model_mem[mem_addr] = mem_dq_out;
    if (!mem_ce_n && !mem_oe_n)
      mem_dq_in <= model_mem.exists(mem_addr) ? model_mem[mem_addr] : init_val(mem_addr);
    else
      mem_dq_in <= 8'hEE;
  end

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit noisy);
    logic [DW-1:0] e;
    e = exp_read(a);
    issue(1'b0, a, 8'h00);
    if (noisy) begin req = 1'b1; req_wr = 1'b1; req_addr = a ^ 19'h1; req_wdata = 8'hC3; end
    else       begin req = 1'b0; req_addr = ~a; end
    for (int k = 0; k < RD; k++) begin
      if (k > 0) @(negedge clk);
      chk("R2 ce_n", mem_ce_n, 0);
      chk("R2 oe_n", mem_oe_n, 0);
      chk("R2 we_n", mem_we_n, 1);
      chk("R2 dq_oe", mem_dq_oe, 0);
      chk("R9 addr", mem_addr, a);
      chk("R7 ready", ready, 0);
      chk("R3 no early valid", rd_valid, 0);
    end
    @(negedge clk);
    req = 1'b0;
    chk("R3 valid", rd_valid, 1);
    chk("R3 data", rd_data, e);
    chk("R4 ce_n", mem_ce_n, 1);
    chk("R4 oe_n", mem_oe_n, 1);
    chk("R4 dq_oe", mem_dq_oe, 0);
    chk("R7 ready busy", ready, 0);
    for (int k = 1; k < TA; k++) begin
      @(negedge clk);
      chk("R4 release", mem_ce_n & mem_oe_n & ~mem_dq_oe, 1);
      chk("R7 ready busy", ready, 0);
    end
    @(negedge clk);
    chk("R7 ready back", ready, 1);
    chk("R3 single pulse", rd_valid, 0);
    chk("R3 data held", rd_data, e);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    issue(1'b1, a, d);
    req = 1'b0; req_addr = ~a; req_wdata = ~d;
    for (int k = 0; k < WE; k++) begin
      if (k > 0) @(negedge clk);
      chk("R5 we_n", mem_we_n, 0);
      chk("R5 ce_n", mem_ce_n, 0);
      chk("R5 oe_n", mem_oe_n, 1);
      chk("R5 dq_oe", mem_dq_oe, 1);
      chk("R5 dq_out", mem_dq_out, d);
      chk("R5 addr", mem_addr, a);
      chk("R7 ready", ready, 0);
    end
    @(negedge clk);
    chk("R6 strobes up", mem_we_n & mem_ce_n, 1);
    chk("R6 hold drive", mem_dq_oe, 1);
    chk("R6 hold data", mem_dq_out, d);
    @(negedge clk);
    chk("R6 release", mem_dq_oe, 0);
    chk("R7 ready back", ready, 1);
    exp_mem[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R7 watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [AW-1:0] pool [8];
    void'($urandom(32'd2024));
    rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 ce_n", mem_ce_n, 1);
    chk("R1 oe_n", mem_oe_n, 1);
    chk("R1 we_n", mem_we_n, 1);
    chk("R1 dq_oe", mem_dq_oe, 0);
    chk("R1 ready", ready, 1);
    chk("R1 valid", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {ready, mem_ce_n, mem_dq_oe}, 3'b110);

    // directed corners: range ends, back-to-back turn-arounds
    do_read(19'h00000, 1'b0);
    do_write(19'h7FFFF, 8'hFF);
    do_read(19'h7FFFF, 1'b0);
    do_write(19'h00000, 8'h00);
    do_write(19'h00001, 8'hA5);
    do_read(19'h00000, 1'b0);
    do_read(19'h00001, 1'b0);

    // request held high while busy must not start an access (R7)
    do_read(19'h12344, 1'b1);
    repeat (2) begin
      @(negedge clk);
      chk("R7 no extra access", mem_ce_n, 1);
    end
    do_read(19'h12345, 1'b0);

    // random mix over a small address pool
    for (int i = 0; i < 8; i++) pool[i] = AW'($urandom);
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = pool[$urandom % 8];
      if ($urandom % 2) do_write(a, DW'($urandom));
      else              do_read(a, 1'b0);
    end

    summary();
    $finish;
  end

endmodule